// File: doc/BRIEF.md
# I2C Shared Pool Buffer Manager

This block owns a byte-addressed staging RAM shared by several I2C bus engines, together with one pool control word and one page-select field per bus. Software fills transmit bytes and collects received bytes through a CPU port that moves one to four bytes per access. A bus engine asks for a buffered transfer. The block then works out that bus's window in the RAM, streams bytes out of the window or into it over a simple byte request/response interface, and records how many bytes arrived.

The pool control word packs three byte-wide fields. Bits 15:8 hold the transmit count minus one. Bits 23:16 hold the receive size minus one. Bits 31:24 hold the received count, and only the block writes that field. The window base comes from one of two variants chosen at elaboration. In paged mode it is a page number times 256 plus a word offset. In fixed mode each bus gets an equal stride. Every window address wraps modulo the RAM size.

Top module: `pool_buffer_mgr`

## Requirements
- R1: After reset every pool control word and page field reads zero, both enable vectors are zero, and `tx_valid`, `rx_req` and `xfer_done` are low.
- R2: A software write to a pool control word (`reg_sel`=0) changes bits 23:0 only. Bits 31:24 change only when a receive transfer completes.
- R3: A CPU access moves `cpu_nbm1`+1 bytes starting at `cpu_addr`, little-endian, with the lowest address in bits 7:0. A read returns its data the cycle after `cpu_gnt`, with unused upper bytes zero.
- R4: In paged mode the window base is page×256 + offset×4. The page comes from bits 22:20 of a `reg_sel`=1 write and the offset from pool control bits 5:0.
- R5: In fixed mode the window base is bus number × `WIN_STRIDE`, where the stride is 16 or 32.
- R6: A transmit transfer presents window entries in order, from the start index (0, or 1 when `xfer_skip_first` is set) up to the transmit count minus one. It holds each byte on `tx_data` until `tx_ack`. The bus's `tx_buf_en` bit is high while the transfer runs and low in the cycle `xfer_done` pulses.
- R7: A transmit byte acknowledged with `tx_nak` high is the last byte presented. The transfer then completes.
- R8: A transmit transfer whose start index is beyond the last entry presents no byte and completes.
- R9: A receive transfer stores exactly size bytes at window entries 0 upward. It then writes that size, modulo 256, into bits 31:24 and clears the bus's `rx_buf_en` bit.
- R10: In any cycle the transfer engine accesses the RAM, `cpu_gnt` is low and the CPU access waits.
- R11: Window and CPU byte addresses wrap modulo `RAM_BYTES`.
- R12: `xfer_start` has no effect while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the pool control word, 1 selects the page field |
| reg_bus | input | BW | Bus whose register is written or read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register (page field at bits 22:20) |
| cpu_req | input | 1 | CPU RAM access request, held until granted |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_nbm1 | input | 2 | Bytes in the access minus one |
| cpu_addr | input | AW | Byte address of the lowest byte |
| cpu_wdata | input | 32 | Write data, little-endian |
| cpu_gnt | output | 1 | Access taken this cycle |
| cpu_rdata | output | 32 | Read data, valid the cycle after the grant |
| xfer_start | input | 1 | Start a buffered transfer |
| xfer_bus | input | BW | Requesting bus |
| xfer_rx | input | 1 | 1 = receive, 0 = transmit |
| xfer_skip_first | input | 1 | Transmit starts at entry 1 instead of 0 |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_ack | input | 1 | Line side consumed the byte |
| tx_nak | input | 1 | Byte was not acknowledged; qualified by `tx_ack` |
| rx_req | output | 1 | Engine waits for a received byte |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| tx_buf_en | output | NUM_BUS | Per-bus transmit-buffer enable |
| rx_buf_en | output | NUM_BUS | Per-bus receive-buffer enable |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
The checker watches several properties on every cycle. The CPU is refused in any cycle the engine holds the RAM. At most one enable bit is ever set. An offered transmit byte holds steady until it is acknowledged. Transmit and receive requests never overlap. The received-count field moves only on a completion write. Other properties are data-dependent and only the bench's scenarios can show them: that the bytes leaving the block are the right window entries in the right order, that paged and fixed bases and wrap-around land on the intended RAM bytes, that a NAK cuts the sequence short at the right byte, and that received bytes and the count reach RAM and the register intact.

// File: rtl/pool_pkg.sv
package pool_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TX_RD,
      ST_TX_WAIT,
      ST_RX_WAIT,
      ST_RX_WR,
      ST_DONE
   } eng_state_t;

   localparam int CNT_LSB   = 24;
   localparam int RXSZ_LSB  = 16;
   localparam int TXCNT_LSB = 8;
   localparam int PAGE_LSB  = 20;
   localparam int PAGE_W    = 3;
   localparam int OFF_W     = 6;
   localparam int PAGE_SPAN = 256;
   localparam int OFF_UNIT  = 4;
endpackage

// File: rtl/pool_ram.sv
module pool_ram #(
   parameter int RAM_BYTES = 512,
   parameter int AW        = 9
) (
   input  logic          clk,
   input  logic          cpu_en,
   input  logic          cpu_we,
   input  logic [1:0]    cpu_nbm1,
   input  logic [AW-1:0] cpu_addr,
   input  logic [31:0]   cpu_wdata,
   output logic [31:0]   cpu_rdata,
   input  logic          bus_en,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [7:0]    bus_wdata,
   output logic [7:0]    bus_rdata
);
   logic [7:0]    mem [RAM_BYTES];
   logic [AW-1:0] lane_addr [4];

   for (genvar j = 0; j < 4; j++) begin : g_lane
      assign lane_addr[j] = cpu_addr + AW'(j);
   end

   always_ff @(posedge clk) begin
      if (cpu_en) begin
         for (int j = 0; j < 4; j++) begin
            if (cpu_we) begin
               if (j <= int'(cpu_nbm1)) mem[lane_addr[j]] <= cpu_wdata[8*j +: 8];
            end else begin
               cpu_rdata[8*j +: 8] <= (j <= int'(cpu_nbm1)) ? mem[lane_addr[j]] : 8'h00;
            end
         end
      end
      if (bus_en) begin
         if (bus_we) mem[bus_addr] <= bus_wdata;
         else        bus_rdata     <= mem[bus_addr];
      end
   end
endmodule

// File: rtl/pool_regs.sv
module pool_regs
   import pool_pkg::*;
#(
   parameter int NUM_BUS = 4,
   parameter int BW      = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           sw_we,
   input  logic                           sw_sel,
   input  logic [BW-1:0]                  sw_bus,
   input  logic [31:0]                    sw_wdata,
   input  logic                           hw_we,
   input  logic [BW-1:0]                  hw_bus,
   input  logic [7:0]                     hw_cnt,
   output logic [NUM_BUS-1:0][31:0]       pctl,
   output logic [NUM_BUS-1:0][PAGE_W-1:0] page
);
   for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pctl[b] <= '0;
            page[b] <= '0;
         end else begin
            if (sw_we && sw_bus == BW'(b)) begin
               if (sw_sel) page[b]                  <= sw_wdata[PAGE_LSB +: PAGE_W];
               else        pctl[b][CNT_LSB-1:0]     <= sw_wdata[CNT_LSB-1:0];
            end
            if (hw_we && hw_bus == BW'(b)) pctl[b][31:CNT_LSB] <= hw_cnt;
         end
      end
   end
endmodule

// File: rtl/pool_base.sv
module pool_base
   import pool_pkg::*;
#(
   parameter int NUM_BUS       = 4,
   parameter int BW            = 2,
   parameter int AW            = 9,
   parameter bit FIXED_WINDOWS = 1'b0,
   parameter int WIN_STRIDE    = 16
) (
   input  logic [BW-1:0]     bus,
   input  logic [PAGE_W-1:0] page,
   input  logic [OFF_W-1:0]  offset,
   output logic [AW-1:0]     base
);
   logic [31:0] full;

   if (FIXED_WINDOWS) begin : g_fixed
      logic sel_unused;
      assign sel_unused = ^{page, offset};
      assign full = 32'(bus) * 32'(WIN_STRIDE);
   end else begin : g_paged
      logic sel_unused;
      assign sel_unused = ^bus;
      assign full = 32'(page) * 32'(PAGE_SPAN) + 32'(offset) * 32'(OFF_UNIT);
   end

   assign base = full[AW-1:0];
endmodule

// File: rtl/pool_engine.sv
module pool_engine
   import pool_pkg::*;
#(
   parameter int NUM_BUS = 4,
   parameter int BW      = 2,
   parameter int AW      = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [BW-1:0]      start_bus,
   input  logic               start_rx,
   input  logic               start_first,
   input  logic [AW-1:0]      base,
   input  logic [7:0]         tx_last,
   input  logic [7:0]         rx_last,
   input  logic               tx_ack,
   input  logic               tx_nak,
   input  logic               rx_valid,
   input  logic [7:0]         rx_data,
   output logic               mem_en,
   output logic               mem_we,
   output logic [AW-1:0]      mem_addr,
   output logic [7:0]         mem_wdata,
   input  logic [7:0]         mem_rdata,
   output logic               tx_valid,
   output logic [7:0]         tx_data,
   output logic               rx_req,
   output logic [NUM_BUS-1:0] tx_en,
   output logic [NUM_BUS-1:0] rx_en,
   output logic               done,
   output logic               cnt_we,
   output logic [BW-1:0]      cnt_bus,
   output logic [7:0]         cnt_val
);
   eng_state_t    state;
   logic [BW-1:0] bus_q;
   logic          rx_q;
   logic [AW-1:0] base_q;
   logic [7:0]    idx_q, last_q, rxd_q;
   logic          active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         bus_q  <= '0;
         rx_q   <= 1'b0;
         base_q <= '0;
         idx_q  <= '0;
         last_q <= '0;
         rxd_q  <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               bus_q  <= start_bus;
               rx_q   <= start_rx;
               base_q <= base;
               last_q <= start_rx ? rx_last : tx_last;
               idx_q  <= start_rx ? 8'd0 : {7'd0, start_first};
               if (start_rx)                          state <= ST_RX_WAIT;
               else if (start_first && tx_last == '0) state <= ST_DONE;
               else                                   state <= ST_TX_RD;
            end
            ST_TX_RD: state <= ST_TX_WAIT;
            ST_TX_WAIT: if (tx_ack) begin
               if (tx_nak || idx_q == last_q) state <= ST_DONE;
               else begin
                  idx_q <= idx_q + 8'd1;
                  state <= ST_TX_RD;
               end
            end
            ST_RX_WAIT: if (rx_valid) begin
               rxd_q <= rx_data;
               state <= ST_RX_WR;
            end
            ST_RX_WR: begin
               if (idx_q == last_q) state <= ST_DONE;
               else begin
                  idx_q <= idx_q + 8'd1;
                  state <= ST_RX_WAIT;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign active    = state inside {ST_TX_RD, ST_TX_WAIT, ST_RX_WAIT, ST_RX_WR};
   assign mem_en    = state inside {ST_TX_RD, ST_RX_WR};
   assign mem_we    = (state == ST_RX_WR);
   assign mem_addr  = base_q + AW'(idx_q);
   assign mem_wdata = rxd_q;
   assign tx_valid  = (state == ST_TX_WAIT);
   assign tx_data   = mem_rdata;
   assign rx_req    = (state == ST_RX_WAIT);
   assign done      = (state == ST_DONE);
   assign cnt_we    = done && rx_q;
   assign cnt_bus   = bus_q;
   assign cnt_val   = last_q + 8'd1;

   for (genvar b = 0; b < NUM_BUS; b++) begin : g_en
      assign tx_en[b] = active && !rx_q && bus_q == BW'(b);
      assign rx_en[b] = active &&  rx_q && bus_q == BW'(b);
   end
endmodule

// File: rtl/pool_buffer_mgr.sv
module pool_buffer_mgr
   import pool_pkg::*;
#(
   parameter int  NUM_BUS       = 4,
   parameter int  RAM_BYTES     = 512,
   parameter bit  FIXED_WINDOWS = 1'b0,
   parameter int  WIN_STRIDE    = 16,
   localparam int AW            = $clog2(RAM_BYTES),
   localparam int BW            = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic               reg_sel,
   input  logic [BW-1:0]      reg_bus,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [1:0]         cpu_nbm1,
   input  logic [AW-1:0]      cpu_addr,
   input  logic [31:0]        cpu_wdata,
   output logic               cpu_gnt,
   output logic [31:0]        cpu_rdata,
   input  logic               xfer_start,
   input  logic [BW-1:0]      xfer_bus,
   input  logic               xfer_rx,
   input  logic               xfer_skip_first,
   output logic               tx_valid,
   output logic [7:0]         tx_data,
   input  logic               tx_ack,
   input  logic               tx_nak,
   output logic               rx_req,
   input  logic               rx_valid,
   input  logic [7:0]         rx_data,
   output logic [NUM_BUS-1:0] tx_buf_en,
   output logic [NUM_BUS-1:0] rx_buf_en,
   output logic               xfer_done
);
   if (NUM_BUS < 2) begin : g_bad_bus
      $error("NUM_BUS must be at least 2");
   end
   if ((RAM_BYTES & (RAM_BYTES - 1)) != 0 || RAM_BYTES < 16) begin : g_bad_ram
      $error("RAM_BYTES must be a power of two of at least 16");
   end
   if (FIXED_WINDOWS && WIN_STRIDE != 16 && WIN_STRIDE != 32) begin : g_bad_stride
      $error("WIN_STRIDE must be 16 or 32");
   end

   logic [NUM_BUS-1:0][31:0]       pctl_all;
   logic [NUM_BUS-1:0][PAGE_W-1:0] page_all;
   logic [NUM_BUS*8-1:0]           cnt_flat;
   logic [AW-1:0]                  start_base;
   logic                           bus_mem_en, bus_mem_we;
   logic [AW-1:0]                  bus_mem_addr;
   logic [7:0]                     bus_mem_wdata, bus_mem_rdata;
   logic                           cnt_we;
   logic [BW-1:0]                  cnt_bus;
   logic [7:0]                     cnt_val;

   assign cpu_gnt   = cpu_req && !bus_mem_en;
   assign reg_rdata = reg_sel ? {9'd0, page_all[reg_bus], 20'd0} : pctl_all[reg_bus];

   for (genvar b = 0; b < NUM_BUS; b++) begin : g_cnt
      assign cnt_flat[8*b +: 8] = pctl_all[b][31:CNT_LSB];
   end

   pool_regs #(.NUM_BUS(NUM_BUS), .BW(BW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_we    (reg_we),
      .sw_sel   (reg_sel),
      .sw_bus   (reg_bus),
      .sw_wdata (reg_wdata),
      .hw_we    (cnt_we),
      .hw_bus   (cnt_bus),
      .hw_cnt   (cnt_val),
      .pctl     (pctl_all),
      .page     (page_all)
   );

   pool_base #(
      .NUM_BUS(NUM_BUS), .BW(BW), .AW(AW),
      .FIXED_WINDOWS(FIXED_WINDOWS), .WIN_STRIDE(WIN_STRIDE)
   ) u_base (
      .bus    (xfer_bus),
      .page   (page_all[xfer_bus]),
      .offset (pctl_all[xfer_bus][OFF_W-1:0]),
      .base   (start_base)
   );

   pool_engine #(.NUM_BUS(NUM_BUS), .BW(BW), .AW(AW)) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (xfer_start),
      .start_bus   (xfer_bus),
      .start_rx    (xfer_rx),
      .start_first (xfer_skip_first),
      .base        (start_base),
      .tx_last     (pctl_all[xfer_bus][TXCNT_LSB +: 8]),
      .rx_last     (pctl_all[xfer_bus][RXSZ_LSB +: 8]),
      .tx_ack      (tx_ack),
      .tx_nak      (tx_nak),
      .rx_valid    (rx_valid),
      .rx_data     (rx_data),
      .mem_en      (bus_mem_en),
      .mem_we      (bus_mem_we),
      .mem_addr    (bus_mem_addr),
      .mem_wdata   (bus_mem_wdata),
      .mem_rdata   (bus_mem_rdata),
      .tx_valid    (tx_valid),
      .tx_data     (tx_data),
      .rx_req      (rx_req),
      .tx_en       (tx_buf_en),
      .rx_en       (rx_buf_en),
      .done        (xfer_done),
      .cnt_we      (cnt_we),
      .cnt_bus     (cnt_bus),
      .cnt_val     (cnt_val)
   );

   pool_ram #(.RAM_BYTES(RAM_BYTES), .AW(AW)) u_ram (
      .clk       (clk),
      .cpu_en    (cpu_gnt),
      .cpu_we    (cpu_we),
      .cpu_nbm1  (cpu_nbm1),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .cpu_rdata (cpu_rdata),
      .bus_en    (bus_mem_en),
      .bus_we    (bus_mem_we),
      .bus_addr  (bus_mem_addr),
      .bus_wdata (bus_mem_wdata),
      .bus_rdata (bus_mem_rdata)
   );
endmodule

// File: rtl/pool_buffer_mgr_chk.sv
module pool_buffer_mgr_chk #(
   parameter int NUM_BUS = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cpu_gnt,
   input logic               bus_mem_en,
   input logic               tx_valid,
   input logic [7:0]         tx_data,
   input logic               tx_ack,
   input logic               rx_req,
   input logic               xfer_done,
   input logic [NUM_BUS-1:0] tx_buf_en,
   input logic [NUM_BUS-1:0] rx_buf_en,
   input logic               cnt_we,
   input logic [NUM_BUS*8-1:0] cnt_flat
);
   p_bus_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_mem_en |-> !cpu_gnt);

   p_one_xfer_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_buf_en, rx_buf_en}));

   p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ack) |=> (tx_valid && $stable(tx_data)));

   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> (tx_buf_en == '0 && rx_buf_en == '0 && !tx_valid && !rx_req));

   p_dir_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_req |-> (!tx_valid && tx_buf_en == '0));

   p_cnt_hw_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_we |=> $stable(cnt_flat));
endmodule

bind pool_buffer_mgr pool_buffer_mgr_chk #(.NUM_BUS(NUM_BUS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_gnt    (cpu_gnt),
   .bus_mem_en (bus_mem_en),
   .tx_valid   (tx_valid),
   .tx_data    (tx_data),
   .tx_ack     (tx_ack),
   .rx_req     (rx_req),
   .xfer_done  (xfer_done),
   .tx_buf_en  (tx_buf_en),
   .rx_buf_en  (rx_buf_en),
   .cnt_we     (cnt_we),
   .cnt_flat   (cnt_flat)
);

// File: tb/pool_buffer_mgr_bench.sv
`timescale 1ns/1ps
module pool_buffer_mgr_bench;
   localparam int NB  = 4;
   localparam int RAM = 512;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        reg_we = 0, reg_sel = 0;
   logic [1:0]  reg_bus = 0;
   logic [31:0] reg_wdata = 0, reg_rdata;
   logic        cpu_req = 0, cpu_we = 0;
   logic [1:0]  cpu_nbm1 = 0;
   logic [8:0]  cpu_addr = 0;
   logic [31:0] cpu_wdata = 0, cpu_rdata;
   logic        cpu_gnt;
   logic        xfer_start = 0, xfer_rx = 0, xfer_skip_first = 0;
   logic [1:0]  xfer_bus = 0;
   logic        tx_valid, tx_ack = 0, tx_nak = 0;
   logic [7:0]  tx_data;
   logic        rx_req, rx_valid = 0;
   logic [7:0]  rx_data = 0;
   logic [NB-1:0] tx_buf_en, rx_buf_en;
   logic        xfer_done;

   pool_buffer_mgr u_pool_buffer_mgr (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_sel(reg_sel), .reg_bus(reg_bus), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_nbm1(cpu_nbm1), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_gnt(cpu_gnt), .cpu_rdata(cpu_rdata),
      .xfer_start(xfer_start), .xfer_bus(xfer_bus), .xfer_rx(xfer_rx), .xfer_skip_first(xfer_skip_first),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ack(tx_ack), .tx_nak(tx_nak),
      .rx_req(rx_req), .rx_valid(rx_valid), .rx_data(rx_data),
      .tx_buf_en(tx_buf_en), .rx_buf_en(rx_buf_en), .xfer_done(xfer_done)
   );

   // second instance: fixed-stride windows, 32 bytes per bus
   logic        fx_cpu_req = 0, fx_start = 0, fx_tx_ack = 0;
   logic [8:0]  fx_cpu_addr = 0;
   logic [31:0] fx_cpu_wdata = 0, fx_reg_rdata, fx_cpu_rdata;
   logic [1:0]  fx_bus = 0;
   logic        fx_cpu_gnt, fx_tx_valid, fx_rx_req, fx_done;
   logic [7:0]  fx_tx_data;
   logic [NB-1:0] fx_tx_en, fx_rx_en;

   pool_buffer_mgr #(.FIXED_WINDOWS(1'b1), .WIN_STRIDE(32)) u_fixed (
      .clk(clk), .rst_n(rst_n),
      .reg_we(1'b0), .reg_sel(1'b0), .reg_bus(2'd0), .reg_wdata(32'd0), .reg_rdata(fx_reg_rdata),
      .cpu_req(fx_cpu_req), .cpu_we(1'b1), .cpu_nbm1(2'd0), .cpu_addr(fx_cpu_addr),
      .cpu_wdata(fx_cpu_wdata), .cpu_gnt(fx_cpu_gnt), .cpu_rdata(fx_cpu_rdata),
      .xfer_start(fx_start), .xfer_bus(fx_bus), .xfer_rx(1'b0), .xfer_skip_first(1'b0),
      .tx_valid(fx_tx_valid), .tx_data(fx_tx_data), .tx_ack(fx_tx_ack), .tx_nak(1'b0),
      .rx_req(fx_rx_req), .rx_valid(1'b0), .rx_data(8'd0),
      .tx_buf_en(fx_tx_en), .rx_buf_en(fx_rx_en), .xfer_done(fx_done)
   );

   int checks = 0;
   int errors = 0;
   logic [7:0] got [256];

   // vector: [30:28] page, [25:20] offset, [16] skip first, [15:8] tx count-1, [7:0] NAK index (FF none)
   localparam logic [31:0] VEC [4] = '{
      {1'b0, 3'd0, 2'b0, 6'd3,  3'b0, 1'b0, 8'd3, 8'hFF},
      {1'b0, 3'd2, 2'b0, 6'd5,  3'b0, 1'b1, 8'd5, 8'hFF},
      {1'b0, 3'd1, 2'b0, 6'd63, 3'b0, 1'b0, 8'd7, 8'd5},
      {1'b0, 3'd0, 2'b0, 6'd0,  3'b0, 1'b1, 8'd0, 8'hFF}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input int bus, input logic sel, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1; reg_sel = sel; reg_bus = 2'(bus); reg_wdata = d;
      @(negedge clk);
      reg_we = 0;
   endtask

   task automatic reg_rd(input int bus, input logic sel, output logic [31:0] d);
      @(negedge clk);
      reg_sel = sel; reg_bus = 2'(bus);
      #1 d = reg_rdata;
   endtask

   task automatic cpu_op(input logic we, input logic [1:0] nbm1, input int addr,
                         input logic [31:0] wd, output logic [31:0] rd);
      @(negedge clk);
      cpu_req = 1; cpu_we = we; cpu_nbm1 = nbm1; cpu_addr = 9'(addr); cpu_wdata = wd;
      #1;
      while (!cpu_gnt) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      cpu_req = 0;
      rd = cpu_rdata;
   endtask

   task automatic run_tx(input int bus, input logic first, input int nak_at, output int n);
      n = 0;
      @(negedge clk);
      xfer_start = 1; xfer_bus = 2'(bus); xfer_rx = 0; xfer_skip_first = first;
      @(negedge clk);
      xfer_start = 0;
      while (!xfer_done) begin
         if (tx_valid && !tx_ack) begin
            got[n] = tx_data;
            tx_nak = (n == nak_at);
            tx_ack = 1;
            n++;
         end
         @(negedge clk);
         tx_ack = 0; tx_nak = 0;
      end
      chk("R6 enables clear at done", 32'({tx_buf_en, rx_buf_en}), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      for (int b = 0; b < NB; b++) begin
         reg_rd(b, 0, rd); chk("R1 pool word zero", rd, 32'd0);
         reg_rd(b, 1, rd); chk("R1 page zero", rd, 32'd0);
      end
      chk("R1 outputs idle", 32'({tx_valid, rx_req, xfer_done, tx_buf_en, rx_buf_en}), 32'd0);

      // R2 software cannot write the received count
      reg_wr(3, 0, 32'hFFFF_FFFF);
      reg_rd(3, 0, rd); chk("R2 upper byte protected", rd, 32'h00FF_FFFF);
      reg_wr(3, 0, 32'h0);

      // R3 little-endian multi-byte access
      cpu_op(1, 2'd3, 16'h10, 32'h4433_2211, rd);
      cpu_op(0, 2'd0, 16'h12, 0, rd); chk("R3 byte read", rd, 32'h0000_0033);
      cpu_op(0, 2'd1, 16'h11, 0, rd); chk("R3 half read", rd, 32'h0000_3322);
      cpu_op(0, 2'd3, 16'h10, 0, rd); chk("R3 word read", rd, 32'h4433_2211);
      cpu_op(1, 2'd0, 16'h13, 32'h77, rd);
      cpu_op(0, 2'd3, 16'h10, 0, rd); chk("R3 byte write merge", rd, 32'h7733_2211);
      // R11 CPU address wrap
      cpu_op(1, 2'd1, 16'h1FF, 32'hBEEF, rd);
      cpu_op(0, 2'd0, 16'h000, 0, rd); chk("R11 cpu wrap high byte", rd, 32'h0000_00BE);
      cpu_op(0, 2'd0, 16'h1FF, 0, rd); chk("R11 cpu wrap low byte", rd, 32'h0000_00EF);

      // table walk: R4 paged base, R6 order, R7 NAK, R8 empty, R11 window wrap
      for (int k = 0; k < 4; k++) begin
         int bus, page, off, m1, nak, base, total, exp_n;
         logic first;
         string tag;
         bus = k % NB;
         page = int'(VEC[k][30:28]); off = int'(VEC[k][25:20]);
         first = VEC[k][16]; m1 = int'(VEC[k][15:8]); nak = int'(VEC[k][7:0]);
         base = (page * 256 + off * 4) % RAM;
         reg_wr(bus, 1, 32'(page) << 20);
         reg_wr(bus, 0, (32'(m1) << 8) | 32'(off));
         for (int i = 0; i <= m1; i++)
            cpu_op(1, 2'd0, (base + i) % RAM, 32'(8'(8'h30 + k * 16 + i)), rd);
         total = m1 + 1 - int'(first);
         exp_n = (nak != 255 && nak + 1 < total) ? nak + 1 : total;
         tag = (nak != 255) ? "R7/R11 nak stop" : ((total == 0) ? "R8 nothing sent" : "R4/R6 paged sequence");
         run_tx(bus, first, nak, n);
         chk(tag, 32'(n), 32'(exp_n));
         for (int i = 0; i < exp_n && i < n; i++)
            chk({tag, " byte"}, 32'(got[i]), 32'(8'(8'h30 + k * 16 + i + int'(first))));
      end

      // R9 receive fill and count write-back, R12 start ignored while busy
      cpu_op(1, 2'd3, 8, 32'h0, rd);
      reg_wr(1, 1, 32'h0);
      reg_wr(1, 0, 32'h0002_0002);
      @(negedge clk);
      xfer_start = 1; xfer_bus = 2'd1; xfer_rx = 1; xfer_skip_first = 0;
      @(negedge clk);
      xfer_start = 1; xfer_bus = 2'd3; xfer_rx = 0;
      @(negedge clk);
      xfer_start = 0;
      chk("R12 second start ignored", 32'({tx_buf_en, rx_buf_en}), 32'h0000_0002);
      for (int i = 0; i < 3; i++) begin
         while (!rx_req) @(negedge clk);
         rx_valid = 1; rx_data = 8'(8'hA1 + i);
         @(negedge clk);
         rx_valid = 0;
      end
      while (!xfer_done) @(negedge clk);
      chk("R9 rx enable clear", 32'(rx_buf_en), 32'd0);
      reg_rd(1, 0, rd); chk("R9 count written, R2 low bits kept", rd, 32'h0302_0002);
      cpu_op(0, 2'd3, 8, 0, rd); chk("R9 received bytes", rd, 32'h00A3_A2A1);

      // R10 bus side wins the RAM
      reg_wr(0, 1, 32'h0);
      reg_wr(0, 0, 32'h0);
      cpu_op(1, 2'd0, 0, 32'h99, rd);
      @(negedge clk);
      xfer_start = 1; xfer_bus = 2'd0; xfer_rx = 0; xfer_skip_first = 0;
      @(negedge clk);
      xfer_start = 0;
      cpu_req = 1; cpu_we = 0; cpu_nbm1 = 2'd0; cpu_addr = 9'd0;
      #1 chk("R10 cpu stalled", 32'(cpu_gnt), 32'd0);
      @(negedge clk);
      #1 chk("R10 cpu granted next", 32'(cpu_gnt), 32'd1);
      chk("R6 single byte", 32'(tx_data), 32'h99);
      tx_ack = 1;
      @(negedge clk);
      tx_ack = 0; cpu_req = 0;
      chk("R10 stalled read data", cpu_rdata, 32'h99);
      @(negedge clk);

      // R5 fixed stride windows
      for (int b = 2; b < 4; b++) begin
         @(negedge clk);
         fx_cpu_req = 1; fx_cpu_addr = 9'(b * 32); fx_cpu_wdata = 32'(8'h50 + b);
         @(negedge clk);
         fx_cpu_req = 0;
         fx_start = 1; fx_bus = 2'(b);
         @(negedge clk);
         fx_start = 0;
         while (!fx_tx_valid) @(negedge clk);
         chk("R5 fixed window byte", 32'(fx_tx_data), 32'(8'h50 + b));
         fx_tx_ack = 1;
         @(negedge clk);
         fx_tx_ack = 0;
         @(negedge clk);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule